// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block collects a parameterised set of interrupt input pins and turns each pin event into an outgoing interrupt message. Each message carries an 8-bit vector, a 3-bit delivery code and a 16-bit destination. Every pin owns one redirection entry. The entry chooses the trigger style (edge or level), the polarity, a mask, the vector, the delivery code and the destination.

Software programs the entries through a two-register window. A write to the select register picks either the version word or one half of an entry. A data write then updates that word, and the data read port returns it. Level pins stop signalling once their message is taken. They are rearmed by an end-of-interrupt strobe that carries a vector, and one strobe can rearm several pins that share that vector. When several pins want service, a fixed-priority arbiter places one message at a time on a valid/ready output.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000 (mask set, all other fields zero) and every high word reads 0. The version word reads {8'h00, NUM_PINS-1, 8'h00, VERSION}.
- R2: The low word holds these fields: vector in bits 7:0, delivery code in 10:8, polarity in 13, a read-only remote-pending flag in 14, trigger in 15 (1 = level) and mask in 16. All other low bits read 0. The high word keeps the destination in bits 31:16, and its bits 15:0 read 0.
- R3: Select value 0 addresses the version word. Select 16+2*i addresses the low word of entry i, and 17+2*i addresses its high word. Any other select value reads 0 and ignores writes. Writes to the version word are ignored.
- R4: An edge entry (trigger 0) issues exactly one message for each inactive-to-active transition of its pin. A pin held active does not issue again.
- R5: An edge that arrives while the entry is masked is discarded. Clearing the mask later issues no message for it.
- R6: With polarity 1 the pin is active low. With polarity 0 it is active high.
- R7: A level entry requests while its pin is active, unmasked and its remote-pending flag is clear. Acceptance of its message sets the flag, and no further message issues until the flag clears.
- R8: An end-of-interrupt strobe clears the remote-pending flag of every level entry whose vector matches it. A strobe with any other vector changes nothing.
- R9: A message carries the vector, the delivery code (passed unchanged) and the destination of the entry being served.
- R10: Among requesting pins, the lowest index is served first. Each valid/ready handshake consumes exactly one message.
- R11: Once msg_valid is raised, it stays high and keeps serving the same entry until msg_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Interrupt input pins |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | SEL_W | New select value |
| data_we | input | 1 | Write strobe for the selected word |
| data_wdata | input | 32 | Data written to the selected word |
| data_rdata | output | 32 | Contents of the selected word |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Outgoing message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery code |
| msg_dest | output | 16 | Message destination |

## Verification
The bench uses a four-pin configuration. The register window is swept with several bit patterns on every entry, and every select value is tried. Expected read-back is computed by masking each written pattern with the writable field positions, which separates real fields from read-only and reserved bits. This also exposes aliased or wrongly decoded select values.

Pin stimulus is chosen to tell the behaviours apart:
- edges with the pin held afterwards (one message per edge, no repeat);
- edges hidden behind a mask (dropped, not deferred);
- an active-low pin;
- two level pins that share one vector, raised together. This shows lowest-first ordering, that the remote flag blocks re-issue, and that a non-matching end-of-interrupt has no effect while a matching one rearms both entries.

// File: rtl/irc_pkg.sv
package irc_pkg;

   localparam int VEC_LSB   = 0;
   localparam int MODE_LSB  = 8;
   localparam int POL_BIT   = 13;
   localparam int RMT_BIT   = 14;
   localparam int TRIG_BIT  = 15;
   localparam int MASK_BIT  = 16;
   localparam int DEST_LSB  = 16;
   localparam int LOW_BASE  = 16;

   typedef struct packed {
      logic [15:0] dest;
      logic        mask;
      logic        lvl;
      logic        pol;
      logic [2:0]  mode;
      logic [7:0]  vec;
   } entry_t;

   localparam entry_t ENTRY_RESET = '{dest: 16'h0, mask: 1'b1, lvl: 1'b0,
                                      pol: 1'b0, mode: 3'h0, vec: 8'h0};

   function automatic logic [31:0] pack_low(entry_t e, logic remote);
      logic [31:0] w;
      w = '0;
      w[VEC_LSB +: 8]  = e.vec;
      w[MODE_LSB +: 3] = e.mode;
      w[POL_BIT]       = e.pol;
      w[RMT_BIT]       = remote;
      w[TRIG_BIT]      = e.lvl;
      w[MASK_BIT]      = e.mask;
      return w;
   endfunction

   function automatic logic [31:0] pack_high(entry_t e);
      logic [31:0] w;
      w = '0;
      w[DEST_LSB +: 16] = e.dest;
      return w;
   endfunction

endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
   import irc_pkg::*;
#(
   parameter int          NUM_PINS = 8,
   parameter int          SEL_W    = 8,
   parameter logic [7:0]  VERSION  = 8'h21
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_we,
   input  logic [SEL_W-1:0]      sel_wdata,
   input  logic                  data_we,
   input  logic [31:0]           data_wdata,
   input  logic [NUM_PINS-1:0]   remote_i,
   output logic [31:0]           data_rdata,
   output entry_t [NUM_PINS-1:0] entries_o
);

   localparam int MAX_SEL = LOW_BASE + 2 * NUM_PINS - 1;
   localparam logic [7:0] MAX_IDX = 8'(NUM_PINS - 1);
   localparam logic [31:0] VERSION_WORD = {8'h00, MAX_IDX, 8'h00, VERSION};

   if (NUM_PINS < 1 || NUM_PINS > 120) begin : g_bad_pins
      $error("irc_regfile: NUM_PINS out of range");
   end
   if (MAX_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("irc_regfile: SEL_W too narrow for NUM_PINS");
   end

   logic [SEL_W-1:0]    sel_q;
   logic [NUM_PINS-1:0] hit_low;
   logic [NUM_PINS-1:0] hit_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_we) sel_q <= sel_wdata;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_entry
      assign hit_low[i]  = (sel_q == SEL_W'(LOW_BASE + 2 * i));
      assign hit_high[i] = (sel_q == SEL_W'(LOW_BASE + 2 * i + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries_o[i] <= ENTRY_RESET;
         end else if (data_we && hit_low[i]) begin
            entries_o[i].vec  <= data_wdata[VEC_LSB +: 8];
            entries_o[i].mode <= data_wdata[MODE_LSB +: 3];
            entries_o[i].pol  <= data_wdata[POL_BIT];
            entries_o[i].lvl  <= data_wdata[TRIG_BIT];
            entries_o[i].mask <= data_wdata[MASK_BIT];
         end else if (data_we && hit_high[i]) begin
            entries_o[i].dest <= data_wdata[DEST_LSB +: 16];
         end
      end
   end

   always_comb begin
      data_rdata = '0;
      if (sel_q == '0) data_rdata = VERSION_WORD;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (hit_low[i])  data_rdata = pack_low(entries_o[i], remote_i[i]);
         if (hit_high[i]) data_rdata = pack_high(entries_o[i]);
      end
   end

   // R3
   version_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == '0) |-> (data_rdata == VERSION_WORD));

endmodule

// File: rtl/irc_pin_slot.sv
module irc_pin_slot
   import irc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  entry_t     entry_i,
   input  logic       accept_i,
   input  logic       eoi_valid_i,
   input  logic [7:0] eoi_vec_i,
   output logic       req_o,
   output logic       remote_o
);

   logic active;
   logic prev_q;
   logic edge_pend_q;
   logic remote_q;
   logic rise;
   logic eoi_hit;

   assign active  = pin_i ^ entry_i.pol;
   assign rise    = active & ~prev_q;
   assign eoi_hit = eoi_valid_i && (eoi_vec_i == entry_i.vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         edge_pend_q <= 1'b0;
      else if (accept_i || entry_i.mask || entry_i.lvl)
         edge_pend_q <= 1'b0;
      else if (rise)
         edge_pend_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remote_q <= 1'b0;
      else if (accept_i && entry_i.lvl)
         remote_q <= 1'b1;
      else if (!entry_i.lvl || eoi_hit)
         remote_q <= 1'b0;
   end

   always_comb begin
      if (entry_i.lvl) req_o = active & ~entry_i.mask & ~remote_q;
      else             req_o = edge_pend_q & ~entry_i.mask;
   end

   assign remote_o = remote_q;

   // R5
   masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_i.mask |=> !edge_pend_q);

   // R7
   remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && entry_i.lvl) |=> remote_q);

   // R8
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && entry_i.lvl && !accept_i) |=> !remote_q);

endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] gnt_idx_o,
   output logic [N-1:0]     accept_o
);

   logic             lock_q;
   logic [IDX_W-1:0] lock_idx_q;
   logic [IDX_W-1:0] low_idx;
   logic             fire;

   always_comb begin
      low_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) low_idx = IDX_W'(i);
      end
   end

   assign valid_o   = lock_q | (|req_i);
   assign gnt_idx_o = lock_q ? lock_idx_q : low_idx;
   assign fire      = valid_o & ready_i;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         accept_o[i] = fire && (gnt_idx_o == IDX_W'(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q     <= 1'b0;
         lock_idx_q <= '0;
      end else begin
         lock_q     <= valid_o & ~ready_i;
         lock_idx_q <= gnt_idx_o;
      end
   end

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && gnt_idx_o == $past(gnt_idx_o)));

   // R10
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && req_i[0]) |-> (gnt_idx_o == '0));

   // R10
   single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(accept_o));

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
   import irc_pkg::*;
#(
   parameter int          NUM_PINS = 8,
   parameter int          SEL_W    = 8,
   parameter logic [7:0]  VERSION  = 8'h21
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                sel_we,
   input  logic [SEL_W-1:0]    sel_wdata,
   input  logic                data_we,
   input  logic [31:0]         data_wdata,
   output logic [31:0]         data_rdata,
   input  logic                eoi_valid,
   input  logic [7:0]          eoi_vector,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [7:0]          msg_vector,
   output logic [2:0]          msg_mode,
   output logic [15:0]         msg_dest
);

   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   entry_t [NUM_PINS-1:0] entries;
   logic   [NUM_PINS-1:0] remote;
   logic   [NUM_PINS-1:0] req;
   logic   [NUM_PINS-1:0] accept;
   logic   [IDX_W-1:0]    gnt_idx;

   irc_regfile #(
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W),
      .VERSION  (VERSION)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_we     (sel_we),
      .sel_wdata  (sel_wdata),
      .data_we    (data_we),
      .data_wdata (data_wdata),
      .remote_i   (remote),
      .data_rdata (data_rdata),
      .entries_o  (entries)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_slot
      irc_pin_slot u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_i       (pin_in[i]),
         .entry_i     (entries[i]),
         .accept_i    (accept[i]),
         .eoi_valid_i (eoi_valid),
         .eoi_vec_i   (eoi_vector),
         .req_o       (req[i]),
         .remote_o    (remote[i])
      );
   end

   irc_arbiter #(
      .N     (NUM_PINS),
      .IDX_W (IDX_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req),
      .ready_i   (msg_ready),
      .valid_o   (msg_valid),
      .gnt_idx_o (gnt_idx),
      .accept_o  (accept)
   );

   always_comb begin
      msg_vector = '0;
      msg_mode   = '0;
      msg_dest   = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (gnt_idx == IDX_W'(i)) begin
            msg_vector = entries[i].vec;
            msg_mode   = entries[i].mode;
            msg_dest   = entries[i].dest;
         end
      end
   end

   // R7
   no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && entries[gnt_idx].lvl && !eoi_valid)
         |=> (remote[$past(gnt_idx)]));

endmodule

// File: tb/irq_redirect_ctrl_test.sv
module irq_redirect_ctrl_test;

   localparam int NP = 4;
   localparam logic [7:0] VER = 8'h21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic        sel_we = 1'b0;
   logic [7:0]  sel_wdata = '0;
   logic        data_we = 1'b0;
   logic [31:0] data_wdata = '0;
   logic [31:0] data_rdata;
   logic        eoi_valid = 1'b0;
   logic [7:0]  eoi_vector = '0;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [7:0]  msg_vector;
   logic [2:0]  msg_mode;
   logic [15:0] msg_dest;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_redirect_ctrl #(.NUM_PINS(NP), .SEL_W(8), .VERSION(VER)) uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .sel_we(sel_we), .sel_wdata(sel_wdata),
      .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_dest(msg_dest)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] s, input logic [31:0] d);
      @(negedge clk); sel_we = 1'b1; sel_wdata = s;
      @(negedge clk); sel_we = 1'b0; data_we = 1'b1; data_wdata = d;
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] s, output logic [31:0] d);
      @(negedge clk); sel_we = 1'b1; sel_wdata = s;
      @(negedge clk); sel_we = 1'b0; d = data_rdata;
   endtask

   // caller is at a negedge: check message, then handshake for one cycle
   task automatic take_msg(input string req, input logic [7:0] v,
                           input logic [2:0] m, input logic [15:0] dst);
      check(req, {31'b0, msg_valid}, 32'd1);
      check(req, {24'b0, msg_vector}, {24'b0, v});
      check(req, {29'b0, msg_mode}, {29'b0, m});
      check(req, {16'b0, msg_dest}, {16'b0, dst});
      msg_ready = 1'b1;
      @(negedge clk); msg_ready = 1'b0;
   endtask

   task automatic send_eoi(input logic [7:0] v);
      @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk); eoi_valid = 1'b0;
   endtask

   function automatic logic [31:0] low_word(input logic [7:0] v, input logic [2:0] m,
                                            input bit pol, input bit lvl, input bit msk);
      return {15'b0, msk, lvl, 1'b0, pol, 2'b0, m, v};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] pats [4];
      pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hAAAA_AAAA;
      pats[2] = 32'h5555_5555; pats[3] = 32'h1234_5678;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(8'd0, rd);
      check("R1 version", rd, {8'h00, 8'(NP - 1), 8'h00, VER});
      for (int i = 0; i < NP; i++) begin
         reg_read(8'(16 + 2 * i), rd);
         check("R1 low reset", rd, 32'h0001_0000);
         reg_read(8'(17 + 2 * i), rd);
         check("R1 high reset", rd, 32'h0);
      end
      check("R1 no message", {31'b0, msg_valid}, 32'd0);

      // R2 field sweep, mask kept set
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < NP; i++) begin
            logic [31:0] d;
            d = (pats[p] ^ (32'h0101_0101 * i)) | 32'h0001_0000;
            reg_write(8'(16 + 2 * i), d);
            reg_write(8'(17 + 2 * i), ~d);
         end
         for (int i = 0; i < NP; i++) begin
            logic [31:0] d;
            d = (pats[p] ^ (32'h0101_0101 * i)) | 32'h0001_0000;
            reg_read(8'(16 + 2 * i), rd);
            check("R2 low fields", rd, d & 32'h0001_A7FF);
            reg_read(8'(17 + 2 * i), rd);
            check("R2 high fields", rd, ~d & 32'hFFFF_0000);
         end
      end

      // R3 unused selects and version write
      reg_write(8'd0, 32'hDEAD_BEEF);
      reg_read(8'd0, rd);
      check("R3 version ro", rd, {8'h00, 8'(NP - 1), 8'h00, VER});
      for (int s = 1; s < 256; s++) begin
         if (s >= 16 && s < 16 + 2 * NP) continue;
         reg_write(8'(s), 32'hFFFF_FFFF);
         reg_read(8'(s), rd);
         check("R3 unused select", rd, 32'h0);
      end
      for (int i = 0; i < NP; i++) begin
         logic [31:0] d;
         d = (pats[3] ^ (32'h0101_0101 * i)) | 32'h0001_0000;
         reg_read(8'(16 + 2 * i), rd);
         check("R3 entries untouched", rd, d & 32'h0001_A7FF);
         reg_write(8'(16 + 2 * i), 32'h0001_0000);
         reg_write(8'(17 + 2 * i), 32'h0);
      end

      // R4 / R9 / R11 edge entry 1
      reg_write(8'd19, 32'h1234_0000);
      reg_write(8'd18, low_word(8'h41, 3'd4, 0, 0, 0));
      check("R4 idle", {31'b0, msg_valid}, 32'd0);
      pin_in[1] = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         check("R11 valid held", {31'b0, msg_valid}, 32'd1);
         @(negedge clk);
      end
      take_msg("R9 edge fields", 8'h41, 3'd4, 16'h1234);
      for (int k = 0; k < 3; k++) begin
         check("R4 no repeat while held", {31'b0, msg_valid}, 32'd0);
         @(negedge clk);
      end

      // R5 masked edge dropped
      pin_in[1] = 1'b0;
      reg_write(8'd18, low_word(8'h41, 3'd4, 0, 0, 1));
      pin_in[1] = 1'b1;
      repeat (2) @(negedge clk);
      reg_write(8'd18, low_word(8'h41, 3'd4, 0, 0, 0));
      repeat (2) @(negedge clk);
      check("R5 masked edge dropped", {31'b0, msg_valid}, 32'd0);
      pin_in[1] = 1'b0;
      @(negedge clk); pin_in[1] = 1'b1;
      @(negedge clk);
      take_msg("R4 fresh edge after unmask", 8'h41, 3'd4, 16'h1234);
      check("R4 single message", {31'b0, msg_valid}, 32'd0);
      reg_write(8'd18, 32'h0001_0000);
      pin_in[1] = 1'b0;

      // R6 active-low edge entry 2
      reg_write(8'd21, 32'hBEEF_0000);
      reg_write(8'd20, low_word(8'h52, 3'd2, 1, 0, 1));
      reg_write(8'd20, low_word(8'h52, 3'd2, 1, 0, 0));
      repeat (2) @(negedge clk);
      check("R6 low level no edge", {31'b0, msg_valid}, 32'd0);
      pin_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 rising is inactive", {31'b0, msg_valid}, 32'd0);
      pin_in[2] = 1'b0;
      @(negedge clk);
      take_msg("R6 falling edge fires", 8'h52, 3'd2, 16'hBEEF);
      check("R6 single message", {31'b0, msg_valid}, 32'd0);
      reg_write(8'd20, 32'h0001_0000);

      // R7 / R8 / R10 shared-vector level entries 0 and 3
      reg_write(8'd17, 32'h0A01_0000);
      reg_write(8'd23, 32'h0A03_0000);
      reg_write(8'd16, low_word(8'h60, 3'd1, 0, 1, 0));
      reg_write(8'd22, low_word(8'h60, 3'd3, 0, 1, 0));
      check("R7 inactive level", {31'b0, msg_valid}, 32'd0);
      pin_in[0] = 1'b1; pin_in[3] = 1'b1;
      @(negedge clk);
      take_msg("R10 lowest index first", 8'h60, 3'd1, 16'h0A01);
      take_msg("R10 next pin", 8'h60, 3'd3, 16'h0A03);
      repeat (2) @(negedge clk);
      check("R7 blocked by remote", {31'b0, msg_valid}, 32'd0);
      reg_read(8'd16, rd);
      check("R7 remote flag visible", rd, 32'h0000_C160);
      pin_in[3] = 1'b0;
      send_eoi(8'h61);
      @(negedge clk);
      check("R8 wrong vector ignored", {31'b0, msg_valid}, 32'd0);
      reg_read(8'd22, rd);
      check("R8 remote kept", rd, 32'h0000_C360);
      send_eoi(8'h60);
      take_msg("R8 rearmed pin 0", 8'h60, 3'd1, 16'h0A01);
      check("R8 pin 3 inactive", {31'b0, msg_valid}, 32'd0);
      reg_read(8'd22, rd);
      check("R8 remote cleared on pin 3", rd, 32'h0000_8360);
      pin_in[0] = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule